// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories around it. The address space is cut into sixteen 4 KB regions. A small set of bank registers picks which 16 KB ROM bank, 8 KB cartridge RAM bank, 8 KB video RAM bank and 4 KB work RAM bank each window shows. For every access the decoder names a target memory and forms the byte address inside it in the same cycle, so the memory can be strobed at once.

While an object DMA runs, the CPU must not touch the memories that the DMA is reading from. The decoder holds the active DMA source and a colour-mode flag. It cuts CPU access to the conflicting regions, and the rules differ between colour and mono mode. Access is a plain per-cycle control bus with no back-pressure: every presented access is decoded in the cycle it is presented and needs no handshake. Bank registers are loaded through a single select-and-value port, and the change is visible from the next clock edge.

Top module: `bank_map_decoder`

## Requirements
- R1: After reset the state is as follows: fixed ROM bank 0, switchable ROM bank 1, cartridge RAM bank 0, cartridge RAM flags 0, VRAM bank 0, work RAM bank register 1, DMA source off (code 0) and mono mode.
- R2: Regions 0x0000-0x3FFF and 0x4000-0x7FFF give target ROM (code 1). The address is bank*0x4000 + (addr & 0x3FFF), using the fixed bank for the low window and the switchable bank for the high window.
- R3: 0x8000-0x9FFF gives target VRAM (code 4) at bank*0x2000 + (addr & 0x1FFF). No DMA source ever blocks this region.
- R4: 0xC000-0xCFFF and its mirror 0xE000-0xEFFF give target WRAM (code 5) at addr & 0x0FFF. 0xD000-0xDFFF gives WRAM at b*0x1000 + (addr & 0x0FFF), where b is the 3-bit bank value and a value of 0 selects 1.
- R5: 0xA000-0xBFFF uses flag bit 0 as read enable, bit 1 as write enable and bit 2 as RTC redirect. A disabled read returns target none with map_ff=1. A disabled write gives target none and no strobe. When enabled with bit 2 set, the target is RTC (code 3) at addr & 0x1FFF. Otherwise the target is cartridge RAM (code 2) at bank*0x2000 + (addr & 0x1FFF).
- R6: In colour mode, a DMA source of ROM (1), cartridge RAM (2) or invalid (5-7) blocks 0x0000-0x7FFF and 0xA000-0xBFFF. Work RAM (4) blocks 0xC000-0xEFFF. VRAM (3) and off (0) block nothing.
- R7: In mono mode, a DMA source of ROM, cartridge RAM, work RAM or invalid blocks 0x0000-0x7FFF, 0xA000-0xBFFF and 0xC000-0xEFFF. VRAM and off block nothing.
- R8: A blocked access gives target none and map address 0, with no strobe. If it is a read, it also gives map_ff=1.
- R9: 0xF000-0xFFFF gives target none, map_ff=0 and no strobe, and is left to an outside decoder.
- R10: map_rd is high only for a valid read with a target other than none, and map_wr only for such a write. With cpu_valid low the target is none and map_ff is 0.
- R11: With set_en high at a clock edge, the register named by set_sel takes the low bits of set_val. The select codes are 0 fixed ROM, 1 switchable ROM, 2 cartridge RAM bank, 3 cartridge RAM flags, 4 VRAM bank, 5 work RAM bank, 6 DMA source and 7 colour flag (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_en | input | 1 | Load one bank/state register |
| set_sel | input | 3 | Register select code |
| set_val | input | SET_W (8) | Value to load |
| cpu_valid | input | 1 | CPU access present this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| map_tgt | output | 3 | Target code: 0 none, 1 ROM, 2 cart RAM, 3 RTC, 4 VRAM, 5 WRAM |
| map_addr | output | PA_W (22) | Byte address inside the target |
| map_rd | output | 1 | Read strobe to the target |
| map_wr | output | 1 | Write strobe to the target |
| map_ff | output | 1 | Read data must be forced to 0xFF |

## Verification
On every cycle the assertions check the following: the strobes are exclusive, an idle bus and the top region decode to nothing, VRAM is never cut off, the work RAM fixed and mirror windows land in bank 0 when no DMA runs, and a forced-0xFF read carries no strobe. A load of the DMA source also reaches the guard on the next cycle. The bench sweeps all DMA codes in both modes over every region with reads and writes. Only its scenarios show the exact bank arithmetic, the bank 0 to 1 remap, the flag combinations of cartridge RAM, and the reset values.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int REGIONS = 16;

  localparam logic [2:0] TGT_NONE = 3'd0;
  localparam logic [2:0] TGT_ROM  = 3'd1;
  localparam logic [2:0] TGT_CRAM = 3'd2;
  localparam logic [2:0] TGT_RTC  = 3'd3;
  localparam logic [2:0] TGT_VRAM = 3'd4;
  localparam logic [2:0] TGT_WRAM = 3'd5;

  localparam logic [2:0] DMA_OFF  = 3'd0;
  localparam logic [2:0] DMA_ROM  = 3'd1;
  localparam logic [2:0] DMA_CRAM = 3'd2;
  localparam logic [2:0] DMA_VRAM = 3'd3;
  localparam logic [2:0] DMA_WRAM = 3'd4;

  localparam logic [2:0] SEL_ROM_LO = 3'd0;
  localparam logic [2:0] SEL_ROM_HI = 3'd1;
  localparam logic [2:0] SEL_CRAM_B = 3'd2;
  localparam logic [2:0] SEL_CRAM_F = 3'd3;
  localparam logic [2:0] SEL_VRAM_B = 3'd4;
  localparam logic [2:0] SEL_WRAM_B = 3'd5;
  localparam logic [2:0] SEL_DMA    = 3'd6;
  localparam logic [2:0] SEL_COLOUR = 3'd7;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bmd_bank_regs.sv
module bmd_bank_regs
  import bmd_pkg::*;
#(
  parameter int SET_W  = 8,
  parameter int ROM_BW = 8,
  parameter int CRAM_BW = 4,
  parameter int VRAM_BW = 1,
  parameter int WRAM_BW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [2:0]         set_sel,
  input  logic [SET_W-1:0]   set_val,
  output logic [ROM_BW-1:0]  rom_lo,
  output logic [ROM_BW-1:0]  rom_hi,
  output logic [CRAM_BW-1:0] cram_bank,
  output logic [2:0]         cram_flags,
  output logic [VRAM_BW-1:0] vram_bank,
  output logic [WRAM_BW-1:0] wram_bank,
  output logic [2:0]         dma_src,
  output logic               colour
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_lo     <= '0;
      rom_hi     <= ROM_BW'(1);
      cram_bank  <= '0;
      cram_flags <= '0;
      vram_bank  <= '0;
      wram_bank  <= WRAM_BW'(1);
      dma_src    <= DMA_OFF;
      colour     <= 1'b0;
    end else if (set_en) begin
      case (set_sel)
        SEL_ROM_LO: rom_lo     <= set_val[ROM_BW-1:0];
        SEL_ROM_HI: rom_hi     <= set_val[ROM_BW-1:0];
        SEL_CRAM_B: cram_bank  <= set_val[CRAM_BW-1:0];
        SEL_CRAM_F: cram_flags <= set_val[2:0];
        SEL_VRAM_B: vram_bank  <= set_val[VRAM_BW-1:0];
        SEL_WRAM_B: wram_bank  <= set_val[WRAM_BW-1:0];
        SEL_DMA:    dma_src    <= set_val[2:0];
        default:    colour     <= set_val[0];
      endcase
    end
  end
endmodule

// File: rtl/bmd_dma_guard.sv
module bmd_dma_guard
  import bmd_pkg::*;
(
  input  logic [2:0]         dma_src,
  input  logic               colour,
  output logic [REGIONS-1:0] blk
);
  logic invalid_src, rom_like, rom_side, wram_side;

  always_comb begin
    invalid_src = (dma_src > DMA_WRAM);
    rom_like    = (dma_src == DMA_ROM) || (dma_src == DMA_CRAM) || invalid_src;
    if (colour) begin
      rom_side  = rom_like;
      wram_side = (dma_src == DMA_WRAM);
    end else begin
      rom_side  = rom_like || (dma_src == DMA_WRAM);
      wram_side = rom_side;
    end
  end

  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    if (r < 8 || r == 10 || r == 11) begin : g_cart
      assign blk[r] = rom_side;
    end else if (r >= 12 && r <= 14) begin : g_work
      assign blk[r] = wram_side;
    end else begin : g_free
      assign blk[r] = 1'b0;
    end
  end
endmodule

// File: rtl/bmd_addr_xlate.sv
module bmd_addr_xlate
  import bmd_pkg::*;
#(
  parameter int ROM_BW  = 8,
  parameter int CRAM_BW = 4,
  parameter int VRAM_BW = 1,
  parameter int WRAM_BW = 3,
  parameter int PA_W    = 22
) (
  input  logic               cpu_valid,
  input  logic               cpu_we,
  input  logic [15:0]        cpu_addr,
  input  logic [REGIONS-1:0] blk,
  input  logic [ROM_BW-1:0]  rom_lo,
  input  logic [ROM_BW-1:0]  rom_hi,
  input  logic [CRAM_BW-1:0] cram_bank,
  input  logic [2:0]         cram_flags,
  input  logic [VRAM_BW-1:0] vram_bank,
  input  logic [WRAM_BW-1:0] wram_bank,
  output logic [2:0]         map_tgt,
  output logic [PA_W-1:0]    map_addr,
  output logic               map_rd,
  output logic               map_wr,
  output logic               map_ff
);
  logic [3:0]         region;
  logic [WRAM_BW-1:0] wram_eff;
  logic               cram_ok;

  assign region   = cpu_addr[15:12];
  assign wram_eff = (wram_bank == '0) ? WRAM_BW'(1) : wram_bank;
  assign cram_ok  = cpu_we ? cram_flags[1] : cram_flags[0];

  always_comb begin
    map_tgt  = TGT_NONE;
    map_addr = '0;
    map_ff   = 1'b0;
    if (cpu_valid) begin
      if (blk[region]) begin
        map_ff = ~cpu_we;
      end else begin
        case (region)
          4'h0, 4'h1, 4'h2, 4'h3: begin
            map_tgt  = TGT_ROM;
            map_addr = PA_W'({rom_lo, cpu_addr[13:0]});
          end
          4'h4, 4'h5, 4'h6, 4'h7: begin
            map_tgt  = TGT_ROM;
            map_addr = PA_W'({rom_hi, cpu_addr[13:0]});
          end
          4'h8, 4'h9: begin
            map_tgt  = TGT_VRAM;
            map_addr = PA_W'({vram_bank, cpu_addr[12:0]});
          end
          4'hA, 4'hB: begin
            if (!cram_ok) begin
              map_ff = ~cpu_we;
            end else if (cram_flags[2]) begin
              map_tgt  = TGT_RTC;
              map_addr = PA_W'(cpu_addr[12:0]);
            end else begin
              map_tgt  = TGT_CRAM;
              map_addr = PA_W'({cram_bank, cpu_addr[12:0]});
            end
          end
          4'hC, 4'hE: begin
            map_tgt  = TGT_WRAM;
            map_addr = PA_W'(cpu_addr[11:0]);
          end
          4'hD: begin
            map_tgt  = TGT_WRAM;
            map_addr = PA_W'({wram_eff, cpu_addr[11:0]});
          end
          default: begin
            map_tgt = TGT_NONE;
          end
        endcase
      end
    end
  end

  assign map_rd = cpu_valid && !cpu_we && (map_tgt != TGT_NONE);
  assign map_wr = cpu_valid &&  cpu_we && (map_tgt != TGT_NONE);
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bmd_pkg::*;
#(
  parameter int SET_W   = 8,
  parameter int ROM_BW  = 8,
  parameter int CRAM_BW = 4,
  parameter int VRAM_BW = 1,
  parameter int WRAM_BW = 3,
  localparam int PA_W   = imax(imax(ROM_BW + 14, CRAM_BW + 13),
                               imax(VRAM_BW + 13, WRAM_BW + 12))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [2:0]       set_sel,
  input  logic [SET_W-1:0] set_val,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic [15:0]      cpu_addr,
  output logic [2:0]       map_tgt,
  output logic [PA_W-1:0]  map_addr,
  output logic             map_rd,
  output logic             map_wr,
  output logic             map_ff
);
  logic [ROM_BW-1:0]  rom_lo, rom_hi;
  logic [CRAM_BW-1:0] cram_bank;
  logic [2:0]         cram_flags;
  logic [VRAM_BW-1:0] vram_bank;
  logic [WRAM_BW-1:0] wram_bank;
  logic [2:0]         dma_src;
  logic               colour;
  logic [REGIONS-1:0] blk;

  bmd_bank_regs #(
    .SET_W(SET_W), .ROM_BW(ROM_BW), .CRAM_BW(CRAM_BW),
    .VRAM_BW(VRAM_BW), .WRAM_BW(WRAM_BW)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_sel(set_sel),
    .set_val(set_val), .rom_lo(rom_lo), .rom_hi(rom_hi),
    .cram_bank(cram_bank), .cram_flags(cram_flags), .vram_bank(vram_bank),
    .wram_bank(wram_bank), .dma_src(dma_src), .colour(colour)
  );

  bmd_dma_guard i_guard (
    .dma_src(dma_src), .colour(colour), .blk(blk)
  );

  bmd_addr_xlate #(
    .ROM_BW(ROM_BW), .CRAM_BW(CRAM_BW), .VRAM_BW(VRAM_BW),
    .WRAM_BW(WRAM_BW), .PA_W(PA_W)
  ) i_xlate (
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .blk(blk),
    .rom_lo(rom_lo), .rom_hi(rom_hi), .cram_bank(cram_bank),
    .cram_flags(cram_flags), .vram_bank(vram_bank), .wram_bank(wram_bank),
    .map_tgt(map_tgt), .map_addr(map_addr), .map_rd(map_rd),
    .map_wr(map_wr), .map_ff(map_ff)
  );
endmodule

// File: rtl/bmd_chk.sv
module bmd_chk #(
  parameter int SET_W = 8,
  parameter int PA_W  = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_en,
  input logic [2:0]       set_sel,
  input logic [SET_W-1:0] set_val,
  input logic             cpu_valid,
  input logic             cpu_we,
  input logic [15:0]      cpu_addr,
  input logic [2:0]       map_tgt,
  input logic [PA_W-1:0]  map_addr,
  input logic             map_rd,
  input logic             map_wr,
  input logic             map_ff,
  input logic [2:0]       dma_src
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_rd && map_wr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> (map_tgt == 3'd0 && !map_rd && !map_wr && !map_ff));

  // R9
  top_region_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15:12] == 4'hF) |-> (map_tgt == 3'd0 && !map_ff && !map_rd && !map_wr));

  // R3
  vram_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_addr[15:13] == 3'b100) |-> (map_tgt == 3'd4));

  // R4
  wram_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && dma_src == 3'd0 && (cpu_addr[15:12] == 4'hC || cpu_addr[15:12] == 4'hE))
      |-> (map_tgt == 3'd5 && map_addr[PA_W-1:12] == '0));

  // R8
  ff_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_ff |-> (map_tgt == 3'd0 && !map_rd && !map_wr && !cpu_we));

  // R11
  dma_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_sel == 3'd6) |=> (dma_src == $past(set_val[2:0])));
endmodule

bind bank_map_decoder bmd_chk #(.SET_W(SET_W), .PA_W(PA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_sel(set_sel),
  .set_val(set_val), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .map_tgt(map_tgt), .map_addr(map_addr),
  .map_rd(map_rd), .map_wr(map_wr), .map_ff(map_ff), .dma_src(dma_src)
);

// File: tb/test_bank_map_decoder.sv
module test_bank_map_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_en = 1'b0;
  logic [2:0] set_sel = '0;
  logic [7:0] set_val = '0;
  logic cpu_valid = 1'b0;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [2:0] map_tgt;
  logic [PA_W-1:0] map_addr;
  logic map_rd, map_wr, map_ff;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the register state
  int m_rom_lo, m_rom_hi, m_cram_b, m_flags, m_vram_b, m_wram_b, m_dma, m_colour;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_map_decoder i_bank_map_decoder (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_sel(set_sel),
    .set_val(set_val), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .map_tgt(map_tgt), .map_addr(map_addr),
    .map_rd(map_rd), .map_wr(map_wr), .map_ff(map_ff)
  );

  task automatic set_reg(input int sel, input int val);
    @(negedge clk);
    set_en = 1'b1; set_sel = 3'(sel); set_val = 8'(val);
    @(negedge clk);
    set_en = 1'b0;
    case (sel)
      0: m_rom_lo = val & 8'hFF;
      1: m_rom_hi = val & 8'hFF;
      2: m_cram_b = val & 4'hF;
      3: m_flags  = val & 7;
      4: m_vram_b = val & 1;
      5: m_wram_b = val & 7;
      6: m_dma    = val & 7;
      default: m_colour = val & 1;
    endcase
  endtask

  task automatic model(input int a, input bit we, input bit v,
                       output int tgt, output int pa, output bit rd,
                       output bit wr, output bit ff);
    int reg_n;
    bit inv, grp_c, grp_w, blocked, en;
    tgt = 0; pa = 0; ff = 0;
    reg_n = a / 4096;
    inv = (m_dma >= 5);
    if (m_colour != 0) begin
      grp_c = (m_dma == 1) || (m_dma == 2) || inv;
      grp_w = (m_dma == 4);
    end else begin
      grp_c = (m_dma == 1) || (m_dma == 2) || (m_dma == 4) || inv;
      grp_w = grp_c;
    end
    blocked = ((reg_n < 8 || reg_n == 10 || reg_n == 11) && grp_c) ||
              ((reg_n >= 12 && reg_n <= 14) && grp_w);
    if (v) begin
      if (blocked) ff = !we;
      else if (reg_n < 4) begin tgt = 1; pa = m_rom_lo * 16384 + a % 16384; end
      else if (reg_n < 8) begin tgt = 1; pa = m_rom_hi * 16384 + a % 16384; end
      else if (reg_n < 10) begin tgt = 4; pa = m_vram_b * 8192 + a % 8192; end
      else if (reg_n < 12) begin
        en = we ? ((m_flags & 2) != 0) : ((m_flags & 1) != 0);
        if (!en) ff = !we;
        else if ((m_flags & 4) != 0) begin tgt = 3; pa = a % 8192; end
        else begin tgt = 2; pa = m_cram_b * 8192 + a % 8192; end
      end
      else if (reg_n == 12 || reg_n == 14) begin tgt = 5; pa = a % 4096; end
      else if (reg_n == 13) begin
        tgt = 5; pa = ((m_wram_b == 0) ? 1 : m_wram_b) * 4096 + a % 4096;
      end
    end
    rd = v && !we && tgt != 0;
    wr = v && we && tgt != 0;
  endtask

  task automatic access(input string tag, input int a, input bit we, input bit v);
    int et, ep;
    bit er, ew, ef;
    @(negedge clk);
    cpu_valid = v; cpu_we = we; cpu_addr = 16'(a);
    #2;
    model(a, we, v, et, ep, er, ew, ef);
    checks++;
    if (int'(map_tgt) != et || int'(map_addr) != ep || map_rd != er ||
        map_wr != ew || map_ff != ef) begin
      failures++;
      $display("FAIL %s addr=%h we=%0b v=%0b dma=%0d col=%0d: got tgt=%0d pa=%h rd=%0b wr=%0b ff=%0b exp tgt=%0d pa=%h rd=%0b wr=%0b ff=%0b",
               tag, a, we, v, m_dma, m_colour, map_tgt, map_addr, map_rd, map_wr,
               map_ff, et, ep, er, ew, ef);
    end
  endtask

  function automatic string region_tag(input int a, input bit col, input int dma);
    int r = a / 4096;
    if (dma != 0 && dma != 3 && r != 8 && r != 9 && r != 15) return col ? "R6" : "R7";
    if (r < 8) return "R2";
    if (r < 10) return "R3";
    if (r < 12) return "R5";
    if (r < 15) return "R4";
    return "R9";
  endfunction

  initial begin
    m_rom_lo = 0; m_rom_hi = 1; m_cram_b = 0; m_flags = 0;
    m_vram_b = 0; m_wram_b = 1; m_dma = 0; m_colour = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state seen through the decode of each window
    access("R1", 16'h0123, 1'b0, 1'b1);
    access("R1", 16'h4123, 1'b0, 1'b1);
    access("R1", 16'h8123, 1'b0, 1'b1);
    access("R1", 16'hA123, 1'b0, 1'b1);
    access("R1", 16'hD123, 1'b0, 1'b1);
    access("R1", 16'h3FFF, 1'b1, 1'b1);

    // R11 / R2 / R3: load banks and observe translation
    set_reg(0, 8'h03);
    set_reg(1, 8'h5A);
    set_reg(2, 8'h0B);
    set_reg(4, 1);
    access("R2", 16'h0ABC, 1'b0, 1'b1);
    access("R2", 16'h7FFF, 1'b0, 1'b1);
    access("R11", 16'h4000, 1'b1, 1'b1);
    access("R3", 16'h9FFF, 1'b1, 1'b1);
    set_reg(1, 8'hFF);
    access("R2", 16'h5555, 1'b0, 1'b1);

    // R4: every work RAM bank value, including the 0 -> 1 remap
    for (int b = 0; b < 8; b++) begin
      set_reg(5, b);
      access("R4", 16'hD7A5, 1'b0, 1'b1);
      access("R4", 16'hCFFF, 1'b1, 1'b1);
      access("R4", 16'hE001, 1'b0, 1'b1);
    end

    // R5: every flag combination, read and write, both halves
    for (int f = 0; f < 8; f++) begin
      set_reg(3, f);
      for (int w = 0; w < 2; w++) begin
        access("R5", 16'hA000, w[0], 1'b1);
        access("R5", 16'hBFFF, w[0], 1'b1);
      end
    end

    // R6 / R7 / R8 / R9: every DMA code, both modes, every region
    set_reg(3, 3);
    for (int col = 0; col < 2; col++) begin
      set_reg(7, col);
      for (int d = 0; d < 8; d++) begin
        set_reg(6, d);
        for (int r = 0; r < 16; r++) begin
          for (int w = 0; w < 2; w++) begin
            access(region_tag(r * 4096, col[0], d), r * 4096, w[0], 1'b1);
            access(region_tag(r * 4096, col[0], d), r * 4096 + 16'h07A5, w[0], 1'b1);
            access("R8", r * 4096 + 16'h0FFF, w[0], 1'b1);
          end
        end
      end
    end

    // R10: idle bus decodes to nothing
    set_reg(6, 0);
    for (int r = 0; r < 16; r++) begin
      access("R10", r * 4096 + 16'h0321, r[0], 1'b0);
    end

    // R1: reset again restores state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_rom_lo = 0; m_rom_hi = 1; m_cram_b = 0; m_flags = 0;
    m_vram_b = 0; m_wram_b = 1; m_dma = 0; m_colour = 0;
    access("R1", 16'h4321, 1'b0, 1'b1);
    access("R1", 16'hD321, 1'b0, 1'b1);
    access("R1", 16'hB000, 1'b1, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule